// File: doc/BRIEF.md
# Peaceable Queens Search Engine

This block runs an exhaustive backtracking search on an N by N board for the largest number of queen pairs that can coexist: k white queens and k black queens placed so that no queen shares a row, column, diagonal or anti-diagonal with a queen of the other colour. Queens of the same colour may attack each other. Squares are numbered row by row, so square `i` sits in row `i / N` and column `i % N`. The engine steps a cursor through the squares using row and column counters rather than a divider.

One stack of positions is kept per colour. While both stacks hold the same number of queens, white moves next. Otherwise black moves next. Each colour searches upward from the square after its own last queen. When a candidate collides with an opposite-colour queen in the same row, the cursor jumps straight to the start of the next row.

A branch is abandoned when:
- the end of the board is reached, or
- too few squares remain to beat the best result so far.

Abandoning a branch pops the most recent queen, and the search resumes just after that queen's old square. Three restrictions cut out mirror images:
- the first white queen must stand on square 0;
- the first black queen must stand strictly above the main diagonal;
- no black queen may stand on the main diagonal.

Software or a sequencer pulses `start`, waits for `done`, and then reads the best pair count and one bitmap of squares per colour.

Top module: `pq_search`

## Requirements
- R1: After reset, `busy` and `done` are 0, `best_pairs` is 0, and both bitmaps are all zero.
- R2: A `start` pulse seen while idle or finished makes `busy` 1 and `done` 0 after that clock edge. A `start` seen while `busy` is 1 has no effect: the run takes exactly as many cycles as a run without it.
- R3: When the run ends, `best_pairs` equals the largest k for which two sets of k squares exist that meet all of these conditions:
  - the white set contains square 0;
  - no black square has row equal to column;
  - the lowest-numbered black square has column greater than row;
  - no white square shares a row, column, diagonal (row minus column) or anti-diagonal (row plus column) with a black square.
- R4: Bit i of `best_white` and `best_black` stands for square i. When the run ends, each map has exactly `best_pairs` bits set, and the two maps share no bit.
- R5: No square set in `best_white` attacks a square set in `best_black` along a row, column, diagonal or anti-diagonal.
- R6: Whenever `best_pairs` is nonzero, the reported maps meet all of these conditions:
  - bit 0 of `best_white` is set;
  - no diagonal square (row equal to column) is set in `best_black`;
  - the lowest set bit of `best_black` lies strictly above the diagonal.
- R7: `done` rises on the same edge at which `busy` falls. While `done` is 1 and `start` is 0, `best_pairs`, `best_white` and `best_black` do not change.
- R8: The edge that accepts `start` clears `best_pairs` and both bitmaps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a search; honoured only when not busy |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished; results are valid and held |
| best_pairs | output | $clog2(N*N+1) | Best number of matched queen pairs found |
| best_white | output | N*N | Squares of the white queens in the best placement |
| best_black | output | N*N | Squares of the black queens in the best placement |

## Verification
The bench builds the engine with N = 4. This gives sixteen squares: enough for deep backtracking, row jumps and bound pruning to all occur. It also keeps the whole space small enough that the bench can enumerate every white set containing square 0 (2^15 of them) and derive the optimum independently. The reported maps are judged by the rules in R4 to R6 rather than compared bit for bit, because several optimal placements exist and only the search order picks one. Run lengths are compared across repeated runs to show that a `start` pulse during a search changes nothing.

// File: rtl/pq_pkg.sv
package pq_pkg;

   typedef enum logic [1:0] {
      PQ_IDLE,
      PQ_SEARCH,
      PQ_DONE
   } pq_state_e;

   localparam int PQ_WHITE = 0;
   localparam int PQ_BLACK = 1;

endpackage

// File: rtl/pq_stack.sv
module pq_stack #(
   parameter  int DEPTH = 16,
   parameter  int IW    = 5,
   parameter  int RW    = 3,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push,
   input  logic             pop,
   input  logic [IW-1:0]    in_idx,
   input  logic [RW-1:0]    in_row,
   input  logic [RW-1:0]    in_col,
   output logic [CW-1:0]    count,
   output logic [IW-1:0]    top_idx,
   output logic [RW-1:0]    top_row,
   output logic [RW-1:0]    top_col,
   output logic [DEPTH-1:0] occupancy
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pq_stack: DEPTH must be at least 2");
   end

   logic [IW-1:0]    s_idx [DEPTH];
   logic [RW-1:0]    s_row [DEPTH];
   logic [RW-1:0]    s_col [DEPTH];
   logic [AW-1:0]    wr_ptr, top_ptr;
   logic [DEPTH-1:0] one_hot;

   assign wr_ptr  = AW'(count);
   assign top_ptr = AW'(count - CW'(1));
   assign one_hot = {{(DEPTH-1){1'b0}}, 1'b1};

   assign top_idx = s_idx[top_ptr];
   assign top_row = s_row[top_ptr];
   assign top_col = s_col[top_ptr];

   always_ff @(posedge clk) begin
      if (push) begin
         s_idx[wr_ptr] <= in_idx;
         s_row[wr_ptr] <= in_row;
         s_col[wr_ptr] <= in_col;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         occupancy <= '0;
      end else if (clear) begin
         count     <= '0;
         occupancy <= '0;
      end else if (push) begin
         count     <= count + CW'(1);
         occupancy <= occupancy | (one_hot << in_idx);
      end else if (pop) begin
         count     <= count - CW'(1);
         occupancy <= occupancy & ~(one_hot << top_idx);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CW'(DEPTH)));                                   // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));                                           // R3
   AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));                                                  // R3
   AST_OCC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      CW'($countones(occupancy)) == count);                             // R4

endmodule

// File: rtl/pq_attack.sv
module pq_attack #(
   parameter int N  = 4,
   parameter int RW = 3
) (
   input  logic [RW-1:0]  row,
   input  logic [RW-1:0]  col,
   input  logic [N*N-1:0] opp_map,
   output logic           row_hit,
   output logic           any_hit
);

   if (RW < $clog2(N + 1)) begin : g_bad_rw
      $error("pq_attack: RW too narrow for N");
   end

   logic [N*N-1:0] hit_row, hit_any;
   logic [RW:0]    r1, c1;

   assign r1 = {1'b0, row};
   assign c1 = {1'b0, col};

   for (genvar j = 0; j < N * N; j++) begin : g_sq
      localparam int JR = j / N;
      localparam int JC = j % N;
      assign hit_row[j] = opp_map[j] && (row == RW'(JR));
      assign hit_any[j] = opp_map[j] &&
                          ((row == RW'(JR)) ||
                           (col == RW'(JC)) ||
                           (r1 + (RW+1)'(JC) == c1 + (RW+1)'(JR)) ||
                           (r1 + c1 == (RW+1)'(JR + JC)));
   end

   assign row_hit = |hit_row;
   assign any_hit = |hit_any;

endmodule

// File: rtl/pq_search.sv
module pq_search
   import pq_pkg::*;
#(
   parameter  int N   = 4,
   localparam int NSQ = N * N,
   localparam int IW  = $clog2(NSQ + 1),
   localparam int RW  = $clog2(N + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   output logic           busy,
   output logic           done,
   output logic [IW-1:0]  best_pairs,
   output logic [NSQ-1:0] best_white,
   output logic [NSQ-1:0] best_black
);

   if (N < 2 || N > 8) begin : g_bad_n
      $error("pq_search: N must lie between 2 and 8");
   end

   pq_state_e      state;
   logic [IW-1:0]  cand_idx;
   logic [RW-1:0]  cand_row, cand_col;

   logic [IW-1:0]  cnt     [2];
   logic [IW-1:0]  top_idx [2];
   logic [RW-1:0]  top_row [2];
   logic [RW-1:0]  top_col [2];
   logic [NSQ-1:0] occ     [2];
   logic [1:0]     push_v, pop_v;
   logic           clear_stk;

   assign clear_stk = start && (state != PQ_SEARCH);

   for (genvar c = 0; c < 2; c++) begin : g_colour
      pq_stack #(.DEPTH(NSQ), .IW(IW), .RW(RW)) u_stack (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (clear_stk),
         .push      (push_v[c]),
         .pop       (pop_v[c]),
         .in_idx    (cand_idx),
         .in_row    (cand_row),
         .in_col    (cand_col),
         .count     (cnt[c]),
         .top_idx   (top_idx[c]),
         .top_row   (top_row[c]),
         .top_col   (top_col[c]),
         .occupancy (occ[c])
      );
   end

   // turn = 1 means black moves next (stack counts differ)
   logic           turn, opp;
   logic [IW-1:0]  cnt_turn;
   logic [NSQ-1:0] opp_map;
   logic           row_hit, any_hit;

   assign turn     = cnt[PQ_WHITE] != cnt[PQ_BLACK];
   assign opp      = !turn;
   assign cnt_turn = turn ? cnt[PQ_BLACK] : cnt[PQ_WHITE];
   assign opp_map  = turn ? occ[PQ_WHITE] : occ[PQ_BLACK];

   pq_attack #(.N(N), .RW(RW)) u_attack (
      .row     (cand_row),
      .col     (cand_col),
      .opp_map (opp_map),
      .row_hit (row_hit),
      .any_hit (any_hit)
   );

   // bound: squares left versus queens still needed to beat the best
   logic [IW:0] need, rem;
   logic        give_up, rule_block, legal, finish;

   assign need = {1'b0, best_pairs} + (IW+1)'(1) - {1'b0, cnt_turn};
   assign rem  = (IW+1)'(NSQ) - {1'b0, cand_idx};
   assign give_up = (rem < need) ||
                    (!turn && cnt[PQ_WHITE] == '0 && cand_idx != '0);
   assign rule_block = turn && ((cand_row == cand_col) ||
                                (cnt[PQ_BLACK] == '0 && cand_col <= cand_row));
   assign legal  = !any_hit && !rule_block;
   assign finish = (turn && cnt[PQ_WHITE] == IW'(1)) ||
                   (!turn && cnt[PQ_BLACK] == '0);

   logic [IW-1:0]  base_idx, nxt_idx;
   logic [RW-1:0]  base_row, base_col, nxt_row, nxt_col;
   logic           from_zero, jump_row, go_done, take_best;
   logic [NSQ-1:0] cand_bit;

   assign cand_bit = {{(NSQ-1){1'b0}}, 1'b1} << cand_idx;

   always_comb begin
      base_idx  = cand_idx;
      base_row  = cand_row;
      base_col  = cand_col;
      from_zero = 1'b0;
      jump_row  = 1'b0;
      go_done   = 1'b0;
      take_best = 1'b0;
      push_v    = '0;
      pop_v     = '0;
      if (state == PQ_SEARCH) begin
         if (give_up) begin
            if (finish) begin
               go_done = 1'b1;
            end else begin
               pop_v[opp] = 1'b1;
               base_idx   = top_idx[opp];
               base_row   = top_row[opp];
               base_col   = top_col[opp];
            end
         end else if (legal) begin
            push_v[turn] = 1'b1;
            if (!turn) begin
               if (cnt[PQ_BLACK] == '0) begin
                  from_zero = 1'b1;
               end else begin
                  base_idx = top_idx[PQ_BLACK];
                  base_row = top_row[PQ_BLACK];
                  base_col = top_col[PQ_BLACK];
               end
            end else begin
               base_idx  = top_idx[PQ_WHITE];
               base_row  = top_row[PQ_WHITE];
               base_col  = top_col[PQ_WHITE];
               take_best = (cnt[PQ_BLACK] + IW'(1)) > best_pairs;
            end
         end else if (row_hit) begin
            jump_row = 1'b1;
         end
      end

      if (from_zero) begin
         nxt_idx = '0;
         nxt_row = '0;
         nxt_col = '0;
      end else if (jump_row) begin
         nxt_idx = base_idx + IW'(N) - IW'(base_col);
         nxt_row = base_row + RW'(1);
         nxt_col = '0;
      end else if (base_col == RW'(N - 1)) begin
         nxt_idx = base_idx + IW'(1);
         nxt_row = base_row + RW'(1);
         nxt_col = '0;
      end else begin
         nxt_idx = base_idx + IW'(1);
         nxt_row = base_row;
         nxt_col = base_col + RW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PQ_IDLE;
         cand_idx   <= '0;
         cand_row   <= '0;
         cand_col   <= '0;
         best_pairs <= '0;
         best_white <= '0;
         best_black <= '0;
      end else begin
         case (state)
            PQ_IDLE, PQ_DONE: begin
               if (start) begin
                  state      <= PQ_SEARCH;
                  cand_idx   <= '0;
                  cand_row   <= '0;
                  cand_col   <= '0;
                  best_pairs <= '0;
                  best_white <= '0;
                  best_black <= '0;
               end
            end
            PQ_SEARCH: begin
               if (go_done) begin
                  state <= PQ_DONE;
               end else begin
                  cand_idx <= nxt_idx;
                  cand_row <= nxt_row;
                  cand_col <= nxt_col;
               end
               if (take_best) begin
                  best_pairs <= cnt[PQ_BLACK] + IW'(1);
                  best_white <= occ[PQ_WHITE];
                  best_black <= occ[PQ_BLACK] | cand_bit;
               end
            end
            default: state <= PQ_IDLE;
         endcase
      end
   end

   assign busy = (state == PQ_SEARCH);
   assign done = (state == PQ_DONE);

   logic [NSQ-1:0] diag_mask;
   always_comb begin
      diag_mask = '0;
      for (int k = 0; k < N; k++) diag_mask[k*(N+1)] = 1'b1;
   end

   AST_TURN_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[PQ_WHITE] == cnt[PQ_BLACK]) ||
      (cnt[PQ_WHITE] == cnt[PQ_BLACK] + IW'(1)));                       // R3
   AST_CURSOR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cand_idx == IW'(cand_row) * IW'(N) + IW'(cand_col)));   // R3
   AST_FIRST_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
      (best_pairs != '0) |-> best_white[0]);                            // R6
   AST_BLACK_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
      (best_black & diag_mask) == '0);                                  // R6
   AST_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      (best_white & best_black) == '0);                                 // R4
   AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));                                                 // R7
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(best_pairs) &&
                            $stable(best_white) && $stable(best_black))); // R7
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (best_pairs == '0 && busy));                 // R8

endmodule

// File: tb/tb_pq_search.sv
`timescale 1ns/1ps
module tb_pq_search;

   localparam int N   = 4;
   localparam int NSQ = N * N;
   localparam int IW  = $clog2(NSQ + 1);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           busy, done;
   logic [IW-1:0]  best_pairs;
   logic [NSQ-1:0] best_white, best_black;

   always #2.5 clk = ~clk;

   pq_search #(.N(N)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .best_pairs(best_pairs), .best_white(best_white), .best_black(best_black)
   );

   int total = 0;
   int bad   = 0;
   int exp_q[$];
   logic [NSQ-1:0] att [NSQ];
   logic [NSQ-1:0] diag;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void build_tables();
      diag = '0;
      for (int s = 0; s < NSQ; s++) begin
         att[s] = '0;
         if (s / N == s % N) diag[s] = 1'b1;
         for (int t = 0; t < NSQ; t++) begin
            if ((s / N == t / N) || (s % N == t % N) ||
                (s / N - s % N == t / N - t % N) ||
                (s / N + s % N == t / N + t % N))
               att[s][t] = 1'b1;
         end
      end
   endfunction

   // exhaustive optimum over every white set holding square 0
   function automatic int ref_best();
      int best = 0;
      for (int m = 0; m < (1 << (NSQ - 1)); m++) begin
         logic [NSQ-1:0] wm, cov, fr;
         int s0, nb, pw, v;
         wm  = NSQ'((m << 1) | 1);
         cov = '0;
         for (int s = 0; s < NSQ; s++) if (wm[s]) cov |= att[s];
         fr = ~cov & ~diag;
         s0 = -1;
         for (int s = 0; s < NSQ; s++)
            if (s0 < 0 && fr[s] && (s % N > s / N)) s0 = s;
         nb = 0;
         if (s0 >= 0) for (int s = s0; s < NSQ; s++) if (fr[s]) nb++;
         pw = $countones(wm);
         v  = (pw < nb) ? pw : nb;
         if (v > best) best = v;
      end
      return best;
   endfunction

   // monitor: compares each finished run against the scoreboard
   initial begin
      forever begin
         @(posedge done);
         @(negedge clk);
         if (exp_q.size() == 0) begin
            check(1'b0, "R3", "done without expected item", 1, 0);
         end else begin
            int e;
            bit clash;
            int low;
            e = exp_q.pop_front();
            check(best_pairs == IW'(e), "R3", "best pair count", best_pairs, e);
            check($countones(best_white) == e, "R4", "white popcount",
                  $countones(best_white), e);
            check($countones(best_black) == e, "R4", "black popcount",
                  $countones(best_black), e);
            check((best_white & best_black) == '0, "R4", "maps overlap",
                  best_white & best_black, 0);
            clash = 1'b0;
            for (int i = 0; i < NSQ; i++)
               if (best_white[i] && ((att[i] & best_black) != '0)) clash = 1'b1;
            check(!clash, "R5", "cross attack", clash, 0);
            check(best_white[0] == 1'b1, "R6", "white on square 0", best_white[0], 1);
            check((best_black & diag) == '0, "R6", "black on diagonal",
                  best_black & diag, 0);
            low = -1;
            for (int i = 0; i < NSQ; i++) if (low < 0 && best_black[i]) low = i;
            check(low >= 0 && (low % N > low / N), "R6", "first black above diagonal",
                  low, 0);
            check(busy == 1'b0, "R7", "busy low with done", busy, 0);
         end
      end
   end

   // driver: pushes the expected item, pulses start, measures run length
   task automatic run_search(input int expv, input bit extra_start, output int cycles);
      logic [IW-1:0]  hb;
      logic [NSQ-1:0] hw, hk;
      exp_q.push_back(expv);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2", "busy after start", busy, 1);
      check(done == 1'b0, "R2", "done cleared by start", done, 0);
      check(best_pairs == '0, "R8", "best cleared by start", best_pairs, 0);
      check(best_white == '0 && best_black == '0, "R8", "maps cleared by start",
            best_white | best_black, 0);
      cycles = 1;
      if (extra_start) begin
         repeat (3) begin @(negedge clk); cycles++; end
         start = 1'b1;
         @(negedge clk); cycles++;
         start = 1'b0;
         check(busy == 1'b1, "R2", "busy through ignored start", busy, 1);
      end
      while (!done) begin
         @(negedge clk);
         cycles++;
      end
      hb = best_pairs; hw = best_white; hk = best_black;
      repeat (20) @(negedge clk);
      check(done == 1'b1, "R7", "done held", done, 1);
      check(best_pairs == hb, "R7", "best held", best_pairs, hb);
      check(best_white == hw && best_black == hk, "R7", "maps held",
            best_white ^ hw ^ best_black ^ hk, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R7", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int expv, c1, c2, c3;
      build_tables();
      expv = ref_best();
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R1", "flags in reset", {busy, done}, 0);
      check(best_pairs == '0, "R1", "best in reset", best_pairs, 0);
      check(best_white == '0 && best_black == '0, "R1", "maps in reset",
            best_white | best_black, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", {busy, done}, 0);

      run_search(expv, 1'b0, c1);
      run_search(expv, 1'b1, c2);
      check(c2 == c1, "R2", "run length with ignored start", c2, c1);
      run_search(expv, 1'b0, c3);
      check(c3 == c1, "R8", "restart repeats run", c3, c1);

      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule